// File: doc/BRIEF.md
# Fragment Reassembling Receiver

This block drains a word-wide slot mailbox and rebuilds one message from a run of fragments. Each fragment starts with a header slot that carries its byte length and a flag marking the last fragment. The payload follows in whole 32-bit slots. The receiver turns each slot into bytes and sends them out one per cycle. It stops when the last fragment has been read, when the buffer space granted at start is used up, when a fragment is too large for the space that is left, or when the mailbox stays empty for too long.

A host pulses `start` together with the buffer space in bytes. It then collects the bytes from `out_valid`/`out_byte` until `done` pulses. After `done`, `ok` and `rx_len` stay stable until the next `start`.

The mailbox shows its filled-slot count and its head word. The receiver pops a word with `slot_rd`. The peer waits for a one-cycle `ping` before it sends more data, so the receiver raises `ping` when it has read a fragment that was not the last one and the mailbox is now empty.

Top module: `frag_rx_reassembler`

## Requirements
- R1: A header is popped only while at least one slot is filled. Its byte length is taken from bits 24:16 and its last-fragment flag from bit 31. Bits 15:0 and 30:25 are ignored.
- R2: No payload slot is popped until the mailbox holds all ceil(length/4) payload slots of the current fragment.
- R3: Payload bytes are output in little-endian order within a slot, starting with bits 7:0. The final slot of a fragment whose length is not a multiple of 4 gives only its low length mod 4 bytes. Its upper bytes are never output.
- R4: A fragment longer than the remaining buffer space ends the receive with `ok`=0. Only its header is consumed, none of its bytes are output, and it adds nothing to `rx_len`.
- R5: A zero-length fragment pulses `warn_zero` for one cycle and ends the receive with `ok`=0.
- R6: After a fragment without the last flag has been read, `ping` pulses for one cycle if the mailbox is empty at that point. It does not pulse if slots are still filled.
- R7: Fragments without the last flag are joined in arrival order until a fragment with the flag arrives. `rx_len` is then the sum of all fragment lengths.
- R8: When the buffer space reaches exactly zero after a fragment without the last flag, the receive ends with `ok`=0 and `rx_len` equal to the space. Later slots stay in the mailbox.
- R9: `ok`=1 requires the last flag, a nonzero final fragment and `peer_ready` high when the receive ends. If `ok`=0, `rx_len` still reports the bytes received.
- R10: If no header arrives within TIMEOUT_POLLS polls spaced POLL_CYC cycles apart, the receive ends with `ok`=0 and `rx_len` equal to the bytes received so far.
- R11: Out of reset, `done`, `ok`, `out_valid`, `ping` and `slot_rd` are low. `done` is always a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a receive, sampled while idle |
| buf_space | input | BUF_W | Buffer space in bytes, sampled with start |
| peer_ready | input | 1 | Peer health flag, sampled when the receive ends |
| slot_fill | input | FILL_W | Number of filled mailbox slots |
| slot_data | input | 32 | Head slot of the mailbox |
| slot_rd | output | 1 | Pop the head slot this cycle |
| ping | output | 1 | One-cycle request to the peer for more data |
| out_valid | output | 1 | out_byte holds a message byte |
| out_byte | output | 8 | Reassembled message byte |
| warn_zero | output | 1 | One-cycle flag for a zero-length fragment |
| done | output | 1 | One-cycle end-of-receive pulse |
| ok | output | 1 | Receive succeeded, held after done |
| rx_len | output | BUF_W | Total bytes received, held after done |

## Verification
A corrupted remaining-byte count within a fragment shows up in the cycle after the damaged slot pop. It appears as a byte missing from or added to the output stream, or as a trailing pad byte (0xEE in the bench) appearing on `out_byte`. A wrong remaining-space register shows up at `done` as a wrong `rx_len`, or as a missed oversize or exhaustion stop. That stop also leaves the wrong number of slots in the mailbox, which the bench reads back from the fill count. A wrong wait condition shows up within a few cycles as slots popped before the payload is complete, or as a `ping` issued while data is still waiting.

// File: rtl/frag_rx_pkg.sv
`timescale 1ns/1ps
package frag_rx_pkg;
  localparam int SLOT_W  = 32;
  localparam int FLEN_W  = 9;
  localparam int FLEN_LO = 16;
  localparam int LAST_BIT = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_HWAIT, S_HCHK, S_PWAIT, S_POP, S_EMIT, S_POST, S_FIN
  } rx_state_e;

  function automatic logic [FLEN_W-1:0] hdr_len(input logic [SLOT_W-1:0] h);
    return h[FLEN_LO +: FLEN_W];
  endfunction

  function automatic logic hdr_last(input logic [SLOT_W-1:0] h);
    return h[LAST_BIT];
  endfunction

  // slots needed to carry n bytes, rounded up
  function automatic logic [7:0] slots_for(input logic [FLEN_W-1:0] n);
    logic [FLEN_W:0] t;
    t = {1'b0, n} + 10'd3;
    return t[FLEN_W:2];
  endfunction

  // bytes delivered by the next slot given bytes still owed
  function automatic logic [2:0] bytes_this_slot(input logic [FLEN_W-1:0] rem);
    return (rem >= FLEN_W'(4)) ? 3'd4 : rem[2:0];
  endfunction
endpackage

// File: rtl/frag_poll_timer.sv
`timescale 1ns/1ps
module frag_poll_timer #(
  parameter int POLL_CYC      = 4,
  parameter int TIMEOUT_POLLS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  output logic tick,
  output logic expired
);
  localparam int DIV_W = $clog2(POLL_CYC + 1);
  localparam int CNT_W = $clog2(TIMEOUT_POLLS + 1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick    = active && (div_q == '0);
  assign expired = tick && (cnt_q == CNT_W'(TIMEOUT_POLLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (arm) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      div_q <= DIV_W'(POLL_CYC - 1);
      if (cnt_q != CNT_W'(TIMEOUT_POLLS)) cnt_q <= cnt_q + 1'b1;
    end else if (active) begin
      div_q <= div_q - 1'b1;
    end
  end

  AST_EXPIRE_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !expired);  // R10
endmodule

// File: rtl/frag_unpacker.sv
`timescale 1ns/1ps
module frag_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  nbytes,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  output logic        last
);
  logic [31:0] word_q;
  logic [2:0]  nb_q;
  logic [1:0]  idx_q;
  logic        act_q;

  assign out_valid = act_q;
  assign out_byte  = word_q[{idx_q, 3'b000} +: 8];
  assign last      = act_q && (({1'b0, idx_q} + 3'd1) == nb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      nb_q   <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
    end else if (load) begin
      word_q <= word;
      nb_q   <= nbytes;
      idx_q  <= '0;
      act_q  <= (nbytes != 3'd0);
    end else if (act_q) begin
      if (last) act_q <= 1'b0;
      else      idx_q <= idx_q + 1'b1;
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !act_q);  // R3
  AST_NONEMPTY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (nbytes != 3'd0) && (nbytes <= 3'd4));  // R3
endmodule

// File: rtl/frag_rx_reassembler.sv
`timescale 1ns/1ps
module frag_rx_reassembler
  import frag_rx_pkg::*;
#(
  parameter int BUF_W         = 12,
  parameter int FILL_W        = 8,
  parameter int POLL_CYC      = 4,
  parameter int TIMEOUT_POLLS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUF_W-1:0]  buf_space,
  input  logic              peer_ready,
  input  logic [FILL_W-1:0] slot_fill,
  input  logic [31:0]       slot_data,
  output logic              slot_rd,
  output logic              ping,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              warn_zero,
  output logic              done,
  output logic              ok,
  output logic [BUF_W-1:0]  rx_len
);
  // BUF_W >= FLEN_W and FILL_W >= 8 are assumed by the width casts below
  rx_state_e         state;
  logic [FLEN_W-1:0] len_q, rem_q;
  logic              last_q, abort_q, tout_q;
  logic [BUF_W-1:0]  left_q, total_q;
  logic              done_q, ok_q, ping_q, warn_q;

  logic              tick, expired, waiting, have;
  logic [FILL_W-1:0] need;
  logic [BUF_W-1:0]  len_b, eff_len, left_next;
  logic              oversize, emit_last, unpack_load;
  logic [2:0]        nb;

  assign waiting   = (state == S_HWAIT) || (state == S_PWAIT);
  assign need      = (state == S_PWAIT) ? FILL_W'(slots_for(len_q)) : FILL_W'(1);
  assign have      = tick && (slot_fill >= need);
  assign len_b     = BUF_W'(len_q);
  assign oversize  = len_b > left_q;
  assign eff_len   = abort_q ? '0 : len_b;
  assign left_next = left_q - eff_len;
  assign nb        = bytes_this_slot(rem_q);
  assign unpack_load = (state == S_POP);

  assign slot_rd   = ((state == S_HWAIT) && have) || (state == S_POP);
  assign ping      = ping_q;
  assign warn_zero = warn_q;
  assign done      = done_q;
  assign ok        = ok_q;
  assign rx_len    = total_q;

  frag_poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_POLLS(TIMEOUT_POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(!waiting), .active(waiting),
    .tick(tick), .expired(expired)
  );

  frag_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .load(unpack_load), .word(slot_data), .nbytes(nb),
    .out_valid(out_valid), .out_byte(out_byte), .last(emit_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      len_q   <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
      abort_q <= 1'b0;
      tout_q  <= 1'b0;
      left_q  <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      ping_q  <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ping_q <= 1'b0;
      warn_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          left_q  <= buf_space;
          total_q <= '0;
          ok_q    <= 1'b0;
          abort_q <= 1'b0;
          tout_q  <= 1'b0;
          state   <= S_HWAIT;
        end
        S_HWAIT: if (have) begin
          len_q  <= hdr_len(slot_data);
          last_q <= hdr_last(slot_data);
          state  <= S_HCHK;
        end else if (expired) begin
          tout_q <= 1'b1;
          state  <= S_FIN;
        end
        S_HCHK: if (oversize) begin
          abort_q <= 1'b1;
          state   <= S_POST;
        end else if (len_q == '0) begin
          warn_q <= 1'b1;
          state  <= S_POST;
        end else begin
          rem_q <= len_q;
          state <= S_PWAIT;
        end
        S_PWAIT: if (have) begin
          state <= S_POP;
        end else if (expired) begin
          tout_q <= 1'b1;
          state  <= S_FIN;
        end
        S_POP: begin
          rem_q <= rem_q - FLEN_W'(nb);
          state <= S_EMIT;
        end
        S_EMIT: if (emit_last) state <= (rem_q == '0) ? S_POST : S_POP;
        S_POST: begin
          ping_q  <= !last_q && (slot_fill == '0);
          total_q <= total_q + eff_len;
          left_q  <= left_next;
          state   <= (last_q || eff_len == '0 || left_next == '0) ? S_FIN : S_HWAIT;
        end
        S_FIN: begin
          done_q <= 1'b1;
          ok_q   <= last_q && !abort_q && !tout_q && (len_q != '0) && peer_ready;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RD_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rd |-> (slot_fill != '0));  // R1
  AST_PING_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    ping |-> ($past(state) == S_POST) && ($past(slot_fill) == '0));  // R6
  AST_BYTES_IN_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (left_q != '0));  // R4
  AST_OK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> $past(peer_ready));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R11
endmodule

// File: tb/frag_rx_reassembler_bench.sv
`timescale 1ns/1ps
module frag_rx_reassembler_bench;
  localparam int BUF_W = 12;
  localparam int FILL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BUF_W-1:0] buf_space = '0;
  logic peer_ready = 1'b1;
  logic [FILL_W-1:0] slot_fill;
  logic [31:0] slot_data;
  logic slot_rd, ping, out_valid, warn_zero, done, ok;
  logic [7:0] out_byte;
  logic [BUF_W-1:0] rx_len;

  always #2 clk = ~clk;

  frag_rx_reassembler #(.BUF_W(BUF_W), .FILL_W(FILL_W), .POLL_CYC(4), .TIMEOUT_POLLS(25))
  u_frag_rx_reassembler (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_space(buf_space),
    .peer_ready(peer_ready), .slot_fill(slot_fill), .slot_data(slot_data),
    .slot_rd(slot_rd), .ping(ping), .out_valid(out_valid), .out_byte(out_byte),
    .warn_zero(warn_zero), .done(done), .ok(ok), .rx_len(rx_len)
  );

  // mailbox model
  logic [31:0] mem [0:255];
  logic [7:0] wp = '0;
  logic [7:0] rp;
  assign slot_fill = wp - rp;
  assign slot_data = mem[rp];
  always @(posedge clk) begin
    if (!rst_n) rp <= '0;
    else if (slot_rd) rp <= rp + 8'd1;
  end

  // output monitor, sampled away from the active edge
  logic [7:0] got [0:1023];
  int ngot = 0, nping = 0, nwarn = 0, ndone = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin got[ngot] = out_byte; ngot++; end
      if (ping) nping++;
      if (warn_zero) nwarn++;
      if (done) ndone++;
    end
  end

  logic [7:0] expb [0:1023];
  int nexp = 0;
  int nchk = 0, nfail = 0;
  int b_got, b_ping, b_warn, b_done;

  task automatic chk(input string tag, input int act, input int expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    mem[wp] = w;
    wp = wp + 8'd1;
  endtask

  task automatic push_frag(input bit last, input int len, input bit keep, input int seed);
    push_word({last, 6'd0, 9'(len), 16'hA55A});
    for (int s = 0; s < (len + 3) / 4; s++) begin
      logic [31:0] w;
      w = 32'hEEEE_EEEE;
      for (int b = 0; b < 4; b++) begin
        int i;
        i = s * 4 + b;
        if (i < len) begin
          w[8*b +: 8] = 8'(seed + i * 13);
          if (keep) begin expb[nexp] = 8'(seed + i * 13); nexp++; end
        end
      end
      push_word(w);
    end
  endtask

  task automatic begin_case();
    @(negedge clk);
    nexp = 0;
    b_got = ngot; b_ping = nping; b_warn = nwarn; b_done = ndone;
  endtask

  task automatic kick(input int space);
    @(negedge clk);
    buf_space = BUF_W'(space);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    for (int k = 0; k < 3000 && ndone == b_done; k++) @(negedge clk);
    @(negedge clk);
    chk({tag, " done count"}, ndone - b_done, 1);
  endtask

  task automatic cmp_bytes(input string tag);
    chk({tag, " byte count"}, ngot - b_got, nexp);
    for (int i = 0; i < nexp && i < ngot - b_got; i++)
      chk({tag, " byte value"}, int'(got[b_got + i]), int'(expb[i]));
  endtask

  task automatic flush();
    @(negedge clk);
    wp = rp;
  endtask

  task automatic t_reset();
    chk("R11 done in reset", int'(done), 0);
    chk("R11 ok in reset", int'(ok), 0);
    chk("R11 out_valid in reset", int'(out_valid), 0);
    chk("R11 slot_rd in reset", int'(slot_rd), 0);
    chk("R11 ping in reset", int'(ping), 0);
  endtask

  task automatic t_single();  // R1 R3: odd length, trailing pad bytes must not appear
    begin_case();
    push_frag(1'b1, 10, 1'b1, 5);
    kick(64);
    wait_done("R1");
    chk("R1 ok", int'(ok), 1);
    chk("R1 rx_len", int'(rx_len), 10);
    cmp_bytes("R3");
    chk("R6 no ping on last", nping - b_ping, 0);
  endtask

  task automatic t_multi();  // R7, R6 negative: data waiting so no ping
    begin_case();
    push_frag(1'b0, 8, 1'b1, 40);
    push_frag(1'b0, 3, 1'b1, 90);
    push_frag(1'b1, 5, 1'b1, 120);
    kick(100);
    wait_done("R7");
    chk("R7 ok", int'(ok), 1);
    chk("R7 rx_len", int'(rx_len), 16);
    cmp_bytes("R7");
    chk("R6 no ping while filled", nping - b_ping, 0);
  endtask

  task automatic t_ping();  // R6
    begin_case();
    push_frag(1'b0, 6, 1'b1, 7);
    kick(64);
    for (int k = 0; k < 500 && nping == b_ping; k++) @(negedge clk);
    chk("R6 ping after drained fragment", nping - b_ping, 1);
    push_frag(1'b1, 3, 1'b1, 200);
    wait_done("R6");
    chk("R6 ok", int'(ok), 1);
    chk("R6 rx_len", int'(rx_len), 9);
    cmp_bytes("R6");
    chk("R6 single ping", nping - b_ping, 1);
  endtask

  task automatic t_wait_payload();  // R2
    begin_case();
    push_word({1'b1, 6'd0, 9'd8, 16'h0000});
    push_word(32'h4433_2211);
    expb[0] = 8'h11; expb[1] = 8'h22; expb[2] = 8'h33; expb[3] = 8'h44;
    expb[4] = 8'h55; expb[5] = 8'h66; expb[6] = 8'h77; expb[7] = 8'h88;
    nexp = 8;
    kick(64);
    repeat (40) @(negedge clk);
    chk("R2 no bytes before full payload", ngot - b_got, 0);
    chk("R2 payload slot left in mailbox", int'(slot_fill), 1);
    push_word(32'h8877_6655);
    wait_done("R2");
    chk("R2 ok", int'(ok), 1);
    cmp_bytes("R2");
  endtask

  task automatic t_oversize();  // R4
    begin_case();
    push_frag(1'b1, 12, 1'b0, 3);
    kick(8);
    wait_done("R4");
    chk("R4 ok", int'(ok), 0);
    chk("R4 rx_len", int'(rx_len), 0);
    chk("R4 no bytes", ngot - b_got, 0);
    chk("R4 payload untouched", int'(slot_fill), 3);
    flush();
  endtask

  task automatic t_zero();  // R5
    begin_case();
    push_frag(1'b1, 0, 1'b0, 0);
    kick(64);
    wait_done("R5");
    chk("R5 warn pulse", nwarn - b_warn, 1);
    chk("R5 ok", int'(ok), 0);
    chk("R5 rx_len", int'(rx_len), 0);
  endtask

  task automatic t_exhaust();  // R8
    begin_case();
    push_frag(1'b0, 8, 1'b1, 60);
    push_frag(1'b1, 4, 1'b0, 61);
    kick(8);
    wait_done("R8");
    chk("R8 ok", int'(ok), 0);
    chk("R8 rx_len", int'(rx_len), 8);
    cmp_bytes("R8");
    chk("R8 later slots kept", int'(slot_fill), 2);
    chk("R8 no ping while filled", nping - b_ping, 0);
    flush();
  endtask

  task automatic t_not_ready();  // R9
    begin_case();
    push_frag(1'b1, 5, 1'b1, 33);
    @(negedge clk);
    peer_ready = 1'b0;
    kick(64);
    wait_done("R9");
    chk("R9 ok with peer down", int'(ok), 0);
    chk("R9 rx_len still reported", int'(rx_len), 5);
    cmp_bytes("R9");
    peer_ready = 1'b1;
  endtask

  task automatic t_timeout();  // R10
    begin_case();
    push_frag(1'b0, 4, 1'b1, 77);
    kick(64);
    repeat (60) @(negedge clk);
    chk("R10 not finished early", ndone - b_done, 0);
    wait_done("R10");
    chk("R10 ok", int'(ok), 0);
    chk("R10 rx_len", int'(rx_len), 4);
    cmp_bytes("R10");
    chk("R10 ping before timeout", nping - b_ping, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_ping();
    t_wait_payload();
    t_oversize();
    t_zero();
    t_exhaust();
    t_not_ready();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule